// File: doc/BRIEF.md
# Backward-Propagating Pipeline Flush Controller

This block runs error recovery for a six-stage in-order pipeline. The stages, from fetch to commit, are fetch (IF), decode (ID), execute (EX), memory (MEM), a stabilising stage (ST) and writeback (WB). The first four stage registers can flag a timing fault, one flag each. ST and WB never flag a fault, so they have no error inputs. Committed state is therefore never built from suspect data.

When a stage flags a fault, three things happen:
- The value it hands downstream is swapped for a bubble.
- A flush token is launched at that stage and moves back toward fetch by one stage register per cycle, invalidating each stage it visits.
- Fetch is held while the token is on its way.

When the token has passed fetch, the block sends a one-cycle restart strobe, together with the PC of the faulting instruction. That instruction is the first one that did not complete correctly, so fetch resumes there. Recovery takes a few cycles. In exchange, there is no single-cycle global stall net that would have to reach every stage register within one clock period.

Stage indices are 0 = IF, 1 = ID, 2 = EX, 3 = MEM. A higher index holds an older instruction.

The controller is a three-state machine:
- **S_IDLE**: no recovery is in progress.
- **S_FLUSH**: the token is moving backward. The register `pos` holds the stage it is invalidating.
- **S_RESTART**: the one cycle in which the restart strobe is issued.

Its transitions are:
- **capture**: from S_IDLE or S_RESTART on any fault, to S_FLUSH with `pos` set to the oldest faulting stage.
- **merge**: from S_FLUSH to S_FLUSH when a fault arrives at a stage above `pos`. This reloads `pos` and the restart PC.
- **step**: from S_FLUSH to S_FLUSH when `pos` > 0. This decrements `pos`.
- **reach_pc**: from S_FLUSH to S_RESTART when `pos` = 0.
- **resume**: from S_RESTART to S_IDLE when there is no fault.

Top module: `cflush_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `bubble_o`, `flush_o`, `fetch_hold_o` and `restart_o` are all zero. Asserting reset in the middle of a flush abandons the flush.
- R2: Every stage whose bit of `err_i` is set at a clock edge has its bit of `bubble_o` set for the following cycle. This applies whether or not the fault starts a flush.
- R3: A fault that starts a flush from stage k sets `flush_o` to one-hot bit k in the next cycle. The set bit then moves down by one position per cycle (k-1, then k-2, and so on) until it reaches bit 0 (IF).
- R4: The cycle after `flush_o` bit 0 is set, `restart_o` is high for exactly one cycle and `flush_o` is zero.
- R5: `restart_pc_o` during the restart strobe equals the per-stage PC (`stage_pc_i` slice k, bits k*PCW upward) that the faulting stage k presented in the cycle its fault was accepted.
- R6: When several stages fault in the same cycle with no flush in progress, the stage with the highest index (the oldest instruction) sets both the token start and the restart PC.
- R7: During a flush, a fault at a stage index above the current token position merges with the flush. The restart PC is replaced by that stage's PC, and the token restarts from that stage.
- R8: During a flush, a fault at a stage index at or below the current token position has no effect. The token keeps its walk and the restart PC is unchanged.
- R9: `fetch_hold_o` is high in every cycle in which `flush_o` is non-zero, and low in the restart-strobe cycle.
- R10: A fault arriving in the restart-strobe cycle is captured as a new flush. It follows the same timing as a fault arriving while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_i | input | NSTG | Timing-fault flag per stage, bit 0 = IF |
| stage_pc_i | input | NSTG*PCW | PC held in each stage, stage k in slice k |
| bubble_o | output | NSTG | Replace that stage's output with a bubble this cycle |
| flush_o | output | NSTG | One-hot flush token position, invalidates that stage |
| fetch_hold_o | output | 1 | Hold fetch while a flush is in flight |
| restart_o | output | 1 | One-cycle strobe to restart fetch |
| restart_pc_o | output | PCW | PC at which fetch resumes |

## Verification
The bench targets the cases where a fault meets recovery that is already running.

- **Merge from an older stage.** An older fault arrives behind a younger one. A design that kept the first PC would resume past an instruction that never completed. A design that did not reload the token would skip invalidating stages.
- **Fault on an already-flushed stage.** A younger fault arrives on a stage the token has already reached. A design that accepted it would restart the walk and lose the original PC.
- **Fault in the strobe cycle.** A design that ignored it would drop the fault.
- **Simultaneous faults.** Several stages fault in the same cycle, which exposes a priority encoder that favours the youngest stage.
- **Walk timing.** Off-by-one errors in the walk or the strobe cycle show up as a token or strobe one cycle early or late.

// File: rtl/cflush_pkg.sv
package cflush_pkg;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_FLUSH   = 2'd1,
        S_RESTART = 2'd2
    } fsm_e;

endpackage

// File: rtl/cflush_pick.sv
// Oldest-fault selector: returns the highest set index of the request vector.
module cflush_pick #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/cflush_pcsel.sv
// Picks the PC of one stage out of the flattened per-stage PC bus.
module cflush_pcsel #(
    parameter int N   = 4,
    parameter int W   = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*W-1:0] pcs_i,
    input  logic [IW-1:0]  sel_i,
    output logic [W-1:0]   pc_o
);
    logic [W-1:0] lane [N];

    for (genvar g = 0; g < N; g++) begin : g_lane
        assign lane[g] = pcs_i[g*W +: W];
    end

    always_comb begin
        pc_o = lane[0];
        for (int i = 0; i < N; i++) begin
            if (sel_i == IW'(i)) pc_o = lane[i];
        end
    end
endmodule

// File: rtl/cflush_ctrl.sv
module cflush_ctrl
    import cflush_pkg::*;
#(
    parameter int NSTG = 4,
    parameter int PCW  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSTG-1:0]   err_i,
    input  logic [NSTG*PCW-1:0] stage_pc_i,
    output logic [NSTG-1:0]   bubble_o,
    output logic [NSTG-1:0]   flush_o,
    output logic              fetch_hold_o,
    output logic              restart_o,
    output logic [PCW-1:0]    restart_pc_o
);
    localparam int IW = (NSTG > 1) ? $clog2(NSTG) : 1;

    fsm_e            state_q, state_d;
    logic [IW-1:0]   pos_q, pos_d;
    logic [PCW-1:0]  rpc_q, rpc_d;
    logic [NSTG-1:0] bub_q;

    logic            any_err;
    logic [IW-1:0]   old_idx;
    logic [PCW-1:0]  old_pc;

    cflush_pick #(.N(NSTG)) u_pick (
        .req_i (err_i),
        .any_o (any_err),
        .idx_o (old_idx)
    );

    cflush_pcsel #(.N(NSTG), .W(PCW)) u_pcsel (
        .pcs_i (stage_pc_i),
        .sel_i (old_idx),
        .pc_o  (old_pc)
    );

    // Next-state and capture logic
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        rpc_d   = rpc_q;
        unique case (state_q)
            S_IDLE, S_RESTART: begin
                if (any_err) begin           // capture
                    state_d = S_FLUSH;
                    pos_d   = old_idx;
                    rpc_d   = old_pc;
                end else begin               // resume
                    state_d = S_IDLE;
                end
            end
            S_FLUSH: begin
                if (any_err && (old_idx > pos_q)) begin  // merge
                    pos_d = old_idx;
                    rpc_d = old_pc;
                end else if (pos_q == '0) begin          // reach_pc
                    state_d = S_RESTART;
                end else begin                           // step
                    pos_d = pos_q - IW'(1);
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pos_q   <= '0;
            rpc_q   <= '0;
            bub_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            rpc_q   <= rpc_d;
            bub_q   <= err_i;
        end
    end

    // Outputs
    always_comb begin
        flush_o      = '0;
        fetch_hold_o = 1'b0;
        restart_o    = 1'b0;
        unique case (state_q)
            S_IDLE:    ;
            S_FLUSH: begin
                flush_o      = NSTG'(1) << pos_q;
                fetch_hold_o = 1'b1;
            end
            S_RESTART: restart_o = 1'b1;
            default:   ;
        endcase
    end

    assign bubble_o     = bub_q;
    assign restart_pc_o = rpc_q;
endmodule

// File: rtl/cflush_chk.sv
module cflush_chk #(
    parameter int NSTG = 4,
    parameter int PCW  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSTG-1:0]   err_i,
    input logic [NSTG*PCW-1:0] stage_pc_i,
    input logic [NSTG-1:0]   bubble_o,
    input logic [NSTG-1:0]   flush_o,
    input logic              fetch_hold_o,
    input logic              restart_o,
    input logic [PCW-1:0]    restart_pc_o
);
    p_bubble_tracks_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err_i != '0 |=> bubble_o == $past(err_i));

    p_token_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flush_o));

    p_token_walks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o[NSTG-1:1] != '0 && err_i == '0) |=> flush_o == ($past(flush_o) >> 1));

    p_idle_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_hold_o && err_i != '0) |=> flush_o != '0);

    p_strobe_after_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o[0] && err_i == '0) |=> restart_o && flush_o == '0);

    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |=> !restart_o);

    p_hold_in_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o != '0 |-> fetch_hold_o);

    p_hold_off_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> !fetch_hold_o);

    p_pc_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_hold_o && err_i == '0) |=> $stable(restart_pc_o));
endmodule

bind cflush_ctrl cflush_chk #(.NSTG(NSTG), .PCW(PCW)) u_chk (.*);

// File: tb/tb_cflush_ctrl.sv
`timescale 1ns/1ps
module tb_cflush_ctrl;
    localparam int NSTG = 4;
    localparam int PCW  = 32;

    typedef struct packed {
        logic [NSTG-1:0] mask;
        logic [PCW-1:0]  base;
    } vec_t;

    // Single-shot faults, including simultaneous ones (R6)
    localparam vec_t VECS [7] = '{
        '{4'b0001, 32'h0000_1000},
        '{4'b0010, 32'h0000_2040},
        '{4'b0100, 32'h0000_3080},
        '{4'b1000, 32'h0000_40C0},
        '{4'b0110, 32'h0000_5100},
        '{4'b1011, 32'h0000_6200},
        '{4'b1111, 32'h0000_7300}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NSTG-1:0]      err_i = '0;
    logic [NSTG*PCW-1:0]  stage_pc_i = '0;
    logic [NSTG-1:0]      bubble_o, flush_o;
    logic                 fetch_hold_o, restart_o;
    logic [PCW-1:0]       restart_pc_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cflush_ctrl #(.NSTG(NSTG), .PCW(PCW)) dut (.*);

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Older stages carry lower PCs: stage k holds base - 4k
    task automatic set_pcs(logic [PCW-1:0] base);
        for (int k = 0; k < NSTG; k++)
            stage_pc_i[k*PCW +: PCW] = base - PCW'(4*k);
    endtask

    function automatic int top_bit(logic [NSTG-1:0] m);
        int r = 0;
        for (int k = 0; k < NSTG; k++) if (m[k]) r = k;
        return r;
    endfunction

    task automatic walk_and_restart(int from, logic [PCW-1:0] exp_pc);
        for (int m = 1; m <= from; m++) begin
            @(negedge clk);
            check("R3 walk", 64'(flush_o), 64'(NSTG'(1) << (from - m)));
            check("R9 hold", 64'(fetch_hold_o), 64'd1);
        end
        @(negedge clk);
        check("R4 strobe", 64'(restart_o), 64'd1);
        check("R4 flush clear", 64'(flush_o), 64'd0);
        check("R5 restart pc", 64'(restart_pc_o), 64'(exp_pc));
        check("R9 hold low", 64'(fetch_hold_o), 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 flush", 64'(flush_o), 64'd0);
        check("R1 bubble", 64'(bubble_o), 64'd0);
        check("R1 hold", 64'(fetch_hold_o), 64'd0);
        check("R1 strobe", 64'(restart_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 64'({flush_o, fetch_hold_o, restart_o}), 64'd0);

        // Vector table: R2 R3 R4 R5 R6 R9
        foreach (VECS[v]) begin
            int j;
            j = top_bit(VECS[v].mask);
            err_i = VECS[v].mask;
            set_pcs(VECS[v].base);
            @(negedge clk);
            err_i = '0;
            check("R2 bubble", 64'(bubble_o), 64'(VECS[v].mask));
            check("R6 R3 start", 64'(flush_o), 64'(NSTG'(1) << j));
            check("R9 hold", 64'(fetch_hold_o), 64'd1);
            walk_and_restart(j, VECS[v].base - PCW'(4*j));
            @(negedge clk);
            check("R4 single pulse", 64'(restart_o), 64'd0);
        end

        // R7 merge: ID fault, then older MEM fault next cycle
        err_i = 4'b0010; set_pcs(32'h0000_A000);
        @(negedge clk);
        err_i = 4'b1000; set_pcs(32'h0000_B000);
        @(negedge clk);
        err_i = '0;
        check("R7 token reload", 64'(flush_o), 64'b1000);
        walk_and_restart(3, 32'h0000_B000 - 32'd12);
        @(negedge clk);

        // R8 ignored: MEM fault, then EX fault while token at MEM
        err_i = 4'b1000; set_pcs(32'h0000_C000);
        @(negedge clk);
        err_i = 4'b0100; set_pcs(32'h0000_D000);
        @(negedge clk);
        err_i = '0;
        check("R8 walk kept", 64'(flush_o), 64'b0100);
        check("R2 bubble on ignored", 64'(bubble_o), 64'b0100);
        walk_and_restart(2, 32'h0000_C000 - 32'd12);
        @(negedge clk);

        // R10 fault in the strobe cycle
        err_i = 4'b0001; set_pcs(32'h0000_E000);
        @(negedge clk);
        err_i = '0;
        check("R3 IF start", 64'(flush_o), 64'b0001);
        @(negedge clk);
        check("R4 strobe", 64'(restart_o), 64'd1);
        err_i = 4'b0100; set_pcs(32'h0000_F000);
        @(negedge clk);
        err_i = '0;
        check("R10 recapture", 64'(flush_o), 64'b0100);
        check("R10 hold", 64'(fetch_hold_o), 64'd1);
        walk_and_restart(2, 32'h0000_F000 - 32'd8);
        @(negedge clk);

        // R1 reset mid-flush
        err_i = 4'b1000; set_pcs(32'h0000_1234);
        @(negedge clk);
        err_i = '0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-flush reset", 64'({flush_o, fetch_hold_o, restart_o}), 64'd0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R1 no late strobe", 64'(restart_o), 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule